// File: doc/BRIEF.md
# TDM Audio Serial Deserializer

This block takes multichannel PCM audio arriving on a single serial data line and turns it into eight parallel signed 24-bit channel samples per frame. The bit clock also serves as the block clock. A frame clock marks the start of each frame. Data is sampled on every rising bit-clock edge, most significant bit first. Once the last sample of a frame is in, all eight samples are presented together and a one-cycle strobe is raised.

Three framings are supported, and a two-bit format input selects between them. The first is a full time-division layout with eight 32-clock slots. The other two are compact single-line layouts that put the four A channels in the first 128-clock half of the frame and the four B channels in the second half, using either 24-clock or 20-clock slots. The format is latched at each frame start. A frame start that arrives before a frame is complete throws the partial frame away and sets a sticky framing-error flag.

Top module: `tdm_deser`

## Requirements
- R1: With format 00, a frame is 256 bit clocks made of eight 32-clock slots. The first 24 bits of each slot are the sample, MSB first, and the remaining 8 bits are ignored. Slot k, in the channel order A1, B1, A2, B2, A3, B3, A4, B4, appears on `samples_o` bits [24k+23:24k].
- R2: With format 10, channel Ax is carried in 24-clock slot x-1 starting at frame bit 0, and channel Bx in slot x-1 starting at frame bit 128. Bits 96 to 127 of each half are ignored. Lane mapping is as in R1.
- R3: With format 01, the slots are 20 clocks wide and carry 20-bit samples placed the same way. Each sample appears left-aligned in its 24-bit lane with its top bit kept as the sign and four zero bits below. Bits 80 to 127 of each half are ignored.
- R4: Format 11 behaves like format 00. The format input is sampled only on the frame-start edge, so a change in mid-frame does not alter how the current frame is decoded.
- R5: A frame starts on a bit-clock rising edge where `fsync` is high and was low at the previous edge. The data bit sampled on that edge is frame bit 0. A single-clock pulse on `fsync` is enough to start a frame.
- R6: `frame_valid_o` is high for exactly one cycle, the cycle after the edge that samples frame bit 255. `samples_o` changes only in that cycle and holds its value at all other times.
- R7: A frame start that arrives after 1 to 255 bits of a frame have been received sets `frame_err_o`, which stays set until reset. The partial frame produces no strobe and leaves `samples_o` unchanged, and the new frame begins at that edge.
- R8: While reset is held, `samples_o` is zero and both `frame_valid_o` and `frame_err_o` are low.
- R9: Bits that arrive after a frame is complete and before the next frame start are ignored. They cause no strobe and no change in `samples_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock; also the block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | Frame clock; its rising edge marks frame bit 0 |
| sdata | input | 1 | Serial audio data, MSB first |
| fmt_i | input | 2 | Framing select: 00 TDM, 01 single-line 20-bit, 10 single-line 24-bit, 11 as 00 |
| samples_o | output | 192 | Eight 24-bit samples, lane k at bits [24k+23:24k] |
| frame_valid_o | output | 1 | One-cycle strobe when a new frame of samples is presented |
| frame_err_o | output | 1 | Sticky flag for a frame start that cut a frame short |

## Verification
The bound checker counts bit clocks since the last frame-clock rising edge and checks on every cycle the properties that depend only on that count. These are: the strobe lands exactly 256 bits after a start and lasts one cycle, the samples hold between strobes, an early start raises the error flag, and the flag never falls. Whether the right bits land in the right lane, with the 20-bit zero fill and the channel interleave of each format, and whether a mid-frame format change is ignored, can only be shown by the bench's frames of known content. The bench's model predicts these values and compares them on every clock.

// File: rtl/tdm_deser_pkg.sv
package tdm_deser_pkg;

   typedef enum logic [1:0] {
      FMT_TDM    = 2'b00,
      FMT_LINE20 = 2'b01,
      FMT_LINE24 = 2'b10,
      FMT_ALT    = 2'b11
   } fmt_e;

   function automatic logic fmt_is_line(input fmt_e f);
      return (f == FMT_LINE20) || (f == FMT_LINE24);
   endfunction

   function automatic logic fmt_is_short(input fmt_e f);
      return f == FMT_LINE20;
   endfunction

endpackage

// File: rtl/tdm_frame_sync.sv
module tdm_frame_sync (
   input  logic clk,
   input  logic rst_n,
   input  logic fsync,
   output logic start
);
   logic fsync_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fsync_q <= 1'b0;
      else        fsync_q <= fsync;
   end

   assign start = fsync & ~fsync_q;
endmodule

// File: rtl/tdm_slot_seq.sv
module tdm_slot_seq
   import tdm_deser_pkg::*;
#(
   parameter int NCH       = 8,
   parameter int FRAME_LEN = 256,
   parameter int TDM_SLOT  = 32,
   parameter int SAMPLE_W  = 24,
   parameter int SHORT_W   = 20
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start,
   input  fmt_e                   fmt_in,
   output logic                   cap_en,
   output logic                   cap_last,
   output logic                   cap_short,
   output logic [$clog2(NCH)-1:0] cap_chan,
   output logic                   frame_end,
   output logic                   overrun
);
   localparam int CW   = $clog2(NCH);
   localparam int PW   = $clog2(FRAME_LEN);
   localparam int BW   = $clog2(TDM_SLOT);
   localparam int HALF = FRAME_LEN / 2;

   localparam logic [PW-1:0] POS_LAST   = PW'(FRAME_LEN - 1);
   localparam logic [PW-1:0] HALF_LAST  = PW'(HALF - 1);
   localparam logic [BW-1:0] TDM_LAST   = BW'(TDM_SLOT - 1);
   localparam logic [BW-1:0] L24_LAST   = BW'(SAMPLE_W - 1);
   localparam logic [BW-1:0] L20_LAST   = BW'(SHORT_W - 1);
   localparam logic [CW-1:0] HALF_SLOTS = CW'(NCH / 2);

   logic          active_q, half_q;
   logic [PW-1:0] pos_q;
   logic [BW-1:0] bit_q;
   logic [CW-1:0] slot_q;
   fmt_e          fmt_q;

   logic          live, half_n, line, shrt;
   logic [PW-1:0] pos_n;
   logic [BW-1:0] bit_n, slot_last, data_last;
   logic [CW-1:0] slot_n;
   fmt_e          fmt_n;

   always_comb begin
      live      = start | active_q;
      pos_n     = start ? '0   : pos_q;
      bit_n     = start ? '0   : bit_q;
      slot_n    = start ? '0   : slot_q;
      half_n    = start ? 1'b0 : half_q;
      fmt_n     = start ? fmt_in : fmt_q;
      line      = fmt_is_line(fmt_n);
      shrt      = fmt_is_short(fmt_n);
      slot_last = line ? (shrt ? L20_LAST : L24_LAST) : TDM_LAST;
      data_last = shrt ? L20_LAST : L24_LAST;
      cap_en    = live && (bit_n <= data_last) && (!line || (slot_n < HALF_SLOTS));
      cap_last  = cap_en && (bit_n == data_last);
      cap_short = shrt;
      cap_chan  = line ? {slot_n[CW-2:0], half_n} : slot_n;
      frame_end = live && (pos_n == POS_LAST);
      overrun   = start & active_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         pos_q    <= '0;
         bit_q    <= '0;
         slot_q   <= '0;
         half_q   <= 1'b0;
         fmt_q    <= FMT_TDM;
      end else if (live) begin
         pos_q    <= pos_n + 1'b1;
         active_q <= (pos_n != POS_LAST);
         fmt_q    <= fmt_n;
         if (line && (pos_n == HALF_LAST)) begin
            bit_q  <= '0;
            slot_q <= '0;
            half_q <= 1'b1;
         end else if (bit_n == slot_last) begin
            bit_q  <= '0;
            slot_q <= slot_n + 1'b1;
            half_q <= half_n;
         end else begin
            bit_q  <= bit_n + 1'b1;
            slot_q <= slot_n;
            half_q <= half_n;
         end
      end
   end
endmodule

// File: rtl/tdm_sample_bank.sv
module tdm_sample_bank #(
   parameter int NCH      = 8,
   parameter int SAMPLE_W = 24,
   parameter int SHORT_W  = 20,
   parameter bit HOLD_OUT = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    sdata,
   input  logic                    cap_en,
   input  logic                    cap_last,
   input  logic                    cap_short,
   input  logic [$clog2(NCH)-1:0]  cap_chan,
   input  logic                    commit,
   output logic [NCH*SAMPLE_W-1:0] samples
);
   localparam int CW  = $clog2(NCH);
   localparam int PAD = SAMPLE_W - SHORT_W;

   logic [SAMPLE_W-1:0] sh_q, shifted, word;

   assign shifted = {sh_q[SAMPLE_W-2:0], sdata};
   assign word    = cap_short ? {shifted[SHORT_W-1:0], {PAD{1'b0}}} : shifted;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sh_q <= '0;
      else if (cap_en) sh_q <= shifted;
   end

   for (genvar g = 0; g < NCH; g++) begin : g_lane
      logic [SAMPLE_W-1:0] work_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                  work_q <= '0;
         else if (cap_last && (cap_chan == CW'(g)))   work_q <= word;
      end

      if (HOLD_OUT) begin : g_hold
         logic [SAMPLE_W-1:0] out_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      out_q <= '0;
            else if (commit) out_q <= work_q;
         end
         assign samples[g*SAMPLE_W +: SAMPLE_W] = out_q;
      end else begin : g_direct
         assign samples[g*SAMPLE_W +: SAMPLE_W] = work_q;
      end
   end
endmodule

// File: rtl/tdm_deser.sv
module tdm_deser
   import tdm_deser_pkg::*;
#(
   parameter int NCH       = 8,
   parameter int SAMPLE_W  = 24,
   parameter int SHORT_W   = 20,
   parameter int TDM_SLOT  = 32,
   parameter int FRAME_LEN = NCH * TDM_SLOT
) (
   input  logic                    bclk,
   input  logic                    rst_n,
   input  logic                    fsync,
   input  logic                    sdata,
   input  logic [1:0]              fmt_i,
   output logic [NCH*SAMPLE_W-1:0] samples_o,
   output logic                    frame_valid_o,
   output logic                    frame_err_o
);
   localparam int CW = $clog2(NCH);

   initial begin
      assert (FRAME_LEN == NCH * TDM_SLOT) else $error("frame length must equal NCH slots");
      assert (NCH >= 2 && NCH % 2 == 0)    else $error("channel count must be even");
      assert (SAMPLE_W <= TDM_SLOT)        else $error("sample wider than slot");
      assert (SHORT_W < SAMPLE_W)          else $error("short width must be narrower");
      assert ((NCH / 2) * SAMPLE_W <= FRAME_LEN / 2) else $error("half too short");
      assert ((FRAME_LEN / 2) / SHORT_W < NCH) else $error("slot index overflow");
   end

   logic          start, cap_en, cap_last, cap_short, frame_end, overrun;
   logic [CW-1:0] cap_chan;
   logic          valid_q, err_q;

   tdm_frame_sync u_sync (
      .clk   (bclk),
      .rst_n (rst_n),
      .fsync (fsync),
      .start (start)
   );

   tdm_slot_seq #(
      .NCH(NCH), .FRAME_LEN(FRAME_LEN), .TDM_SLOT(TDM_SLOT),
      .SAMPLE_W(SAMPLE_W), .SHORT_W(SHORT_W)
   ) u_seq (
      .clk       (bclk),
      .rst_n     (rst_n),
      .start     (start),
      .fmt_in    (fmt_e'(fmt_i)),
      .cap_en    (cap_en),
      .cap_last  (cap_last),
      .cap_short (cap_short),
      .cap_chan  (cap_chan),
      .frame_end (frame_end),
      .overrun   (overrun)
   );

   tdm_sample_bank #(
      .NCH(NCH), .SAMPLE_W(SAMPLE_W), .SHORT_W(SHORT_W), .HOLD_OUT(1'b1)
   ) u_bank (
      .clk       (bclk),
      .rst_n     (rst_n),
      .sdata     (sdata),
      .cap_en    (cap_en),
      .cap_last  (cap_last),
      .cap_short (cap_short),
      .cap_chan  (cap_chan),
      .commit    (frame_end),
      .samples   (samples_o)
   );

   always_ff @(posedge bclk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         valid_q <= frame_end;
         err_q   <= err_q | overrun;
      end
   end

   assign frame_valid_o = valid_q;
   assign frame_err_o   = err_q;
endmodule

// File: rtl/tdm_deser_chk.sv
module tdm_deser_chk #(
   parameter int NCH       = 8,
   parameter int SAMPLE_W  = 24,
   parameter int FRAME_LEN = 256
) (
   input logic                    bclk,
   input logic                    rst_n,
   input logic                    fsync,
   input logic [NCH*SAMPLE_W-1:0] samples_o,
   input logic                    frame_valid_o,
   input logic                    frame_err_o
);
   localparam int CNW = $clog2(FRAME_LEN) + 2;

   logic           fs_q, rise;
   logic [CNW-1:0] seen;

   assign rise = fsync & ~fs_q;

   always_ff @(posedge bclk or negedge rst_n) begin
      if (!rst_n) begin
         fs_q <= 1'b0;
         seen <= '0;
      end else begin
         fs_q <= fsync;
         if (rise)
            seen <= CNW'(1);
         else if ((seen != '0) && (seen <= CNW'(FRAME_LEN)))
            seen <= seen + 1'b1;
      end
   end

   AST_STROBE_AT_FULL_FRAME: assert property (@(posedge bclk) disable iff (!rst_n)
      frame_valid_o |-> (seen == CNW'(FRAME_LEN))); // R6

   AST_STROBE_SINGLE: assert property (@(posedge bclk) disable iff (!rst_n)
      frame_valid_o |=> !frame_valid_o); // R6

   AST_SAMPLES_HOLD: assert property (@(posedge bclk) disable iff (!rst_n)
      !frame_valid_o |-> $stable(samples_o)); // R6

   AST_SHORT_FRAME_FLAG: assert property (@(posedge bclk) disable iff (!rst_n)
      (rise && (seen != '0) && (seen < CNW'(FRAME_LEN))) |=> frame_err_o); // R7

   AST_FLAG_STICKY: assert property (@(posedge bclk) disable iff (!rst_n)
      frame_err_o |=> frame_err_o); // R7
endmodule

bind tdm_deser tdm_deser_chk #(
   .NCH(NCH), .SAMPLE_W(SAMPLE_W), .FRAME_LEN(FRAME_LEN)
) u_chk (
   .bclk          (bclk),
   .rst_n         (rst_n),
   .fsync         (fsync),
   .samples_o     (samples_o),
   .frame_valid_o (frame_valid_o),
   .frame_err_o   (frame_err_o)
);

// File: tb/tdm_deser_test.sv
module tdm_deser_test;
   localparam int NCH = 8;
   localparam int SW  = 24;
   localparam int FL  = 256;
   localparam int VW  = NCH * SW;

   logic          bclk = 1'b0, rst_n = 1'b0, fsync = 1'b0, sdata = 1'b0;
   logic [1:0]    fmt = 2'b00;
   logic [VW-1:0] samples;
   logic          fv, fe;

   tdm_deser uut (
      .bclk(bclk), .rst_n(rst_n), .fsync(fsync), .sdata(sdata), .fmt_i(fmt),
      .samples_o(samples), .frame_valid_o(fv), .frame_err_o(fe)
   );

   always #10 bclk = ~bclk;

   int total = 0, bad = 0;
   bit checking = 1'b0;

   // behavioural reference state
   logic [VW-1:0] exp_s = '0, pend_s = '0;
   logic          exp_v = 1'b0, exp_e = 1'b0, prev_fs = 1'b0;
   int            cnt = 0;
   string         exp_tag = "R8", pend_tag = "";
   logic          fb [FL];

   task automatic chk_vec(input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s samples act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic chk_bit(input string tag, input string what, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s act=%b exp=%b", tag, what, act, exp);
      end
   endtask

   always @(negedge bclk) begin
      if (checking) begin
         chk_bit("R6", "frame_valid", fv, exp_v);
         chk_bit("R7", "frame_err", fe, exp_e);
         chk_vec(exp_tag, samples, exp_s);
      end
   end

   task automatic tick(input logic fs, input logic sd);
      logic st;
      @(negedge bclk);
      fsync = fs;
      sdata = sd;
      @(posedge bclk);
      #1;
      st = fs && !prev_fs;
      prev_fs = fs;
      exp_v = 1'b0;
      if (st) begin
         if (cnt > 0 && cnt < FL) exp_e = 1'b1;
         cnt = 1;
      end else if (cnt > 0 && cnt < FL) begin
         cnt++;
         if (cnt == FL) begin
            exp_v   = 1'b1;
            exp_s   = pend_s;
            exp_tag = pend_tag;
         end
      end
   endtask

   task automatic build(input logic [1:0] m, input string tag);
      logic [SW-1:0] s;
      int w, base, nb;
      for (int i = 0; i < FL; i++) fb[i] = 1'($urandom);
      for (int k = 0; k < NCH; k++) begin
         s = SW'($urandom);
         if (k == 0) s[SW-1] = 1'b1;
         if (m == 2'b01 || m == 2'b10) begin
            w    = (m == 2'b01) ? 20 : 24;
            base = (k % 2) * (FL / 2) + (k / 2) * w;
            nb   = w;
         end else begin
            base = k * 32;
            nb   = 24;
         end
         for (int b = 0; b < nb; b++) fb[base + b] = s[SW-1-b];
         if (m == 2'b01) s[3:0] = 4'b0000;
         pend_s[k*SW +: SW] = s;
      end
      pend_tag = tag;
   endtask

   task automatic frame(input logic [1:0] m, input string tag, input int nbits,
                        input bit pulse, input int swap_at);
      build(m, tag);
      fmt = m;
      for (int i = 0; i < nbits; i++) begin
         if (i == swap_at) fmt = (m == 2'b00) ? 2'b10 : 2'b00;
         tick(pulse ? (i == 0) : (i < FL / 2), fb[i]);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) tick(1'b0, 1'($urandom));
   endtask

   initial begin
      repeat (4) @(posedge bclk);
      // R8: outputs cleared while reset is held
      chk_vec("R8", samples, '0);
      chk_bit("R8", "frame_valid", fv, 1'b0);
      chk_bit("R8", "frame_err", fe, 1'b0);
      @(negedge bclk);
      rst_n = 1'b1;
      checking = 1'b1;

      frame(2'b00, "R1", FL, 1'b0, FL);
      frame(2'b00, "R1", FL, 1'b0, FL);
      frame(2'b10, "R2", FL, 1'b0, FL);
      frame(2'b01, "R3", FL, 1'b0, FL);
      frame(2'b11, "R4", FL, 1'b0, FL);
      frame(2'b00, "R4", FL, 1'b0, 100);
      frame(2'b10, "R4", FL, 1'b0, 60);
      frame(2'b01, "R5", FL, 1'b1, FL);
      exp_tag = "R9";
      idle(40);
      frame(2'b10, "R9", FL, 1'b0, FL);
      frame(2'b00, "R7", 100, 1'b1, FL);
      frame(2'b00, "R7", FL, 1'b0, FL);
      frame(2'b01, "R7", 37, 1'b1, FL);
      frame(2'b10, "R2", FL, 1'b0, FL);
      idle(3);
      checking = 1'b0;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge bclk);
      bad++;
      total++;
      $display("FAIL R6 watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule